// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block holds a 4 KB window of 32-bit system control and status registers on a plain single-cycle bus. A request (`req_valid`, with `req_write` choosing the direction) is taken on a rising clock edge. Read data, the access-error pulse and the soft-reset request all come from registers and are therefore visible in the following cycle. The word is selected by `req_addr[11:2]`, and the two low address bits are ignored.

A write-protection lock guards every ordinary register. A two-state machine holds the lock, with the states `ST_LOCKED` (the state after reset) and `ST_OPEN`. There are two transitions:

- `UNLOCK_KEY_SEEN` moves from `ST_LOCKED` to `ST_OPEN`. It fires on a write of the unlock key to the unlock register.
- `LOCK_KEY_SEEN` moves from `ST_OPEN` to `ST_LOCKED`. It fires on a write of the lock key to the lock register.

Every other request leaves the state where it is.

Each word offset has one access class: read/write, read-only, write-only or unmapped. An illegal access raises a one-cycle error pulse, and so does a write that the lock refuses. A write that sets bit 0 of the reset-control register asks the system for a soft reset.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the block is locked and the registers hold these values: lock status (0x00C) reads 1, PLL control (0x100, 0x104, 0x108) reads 0x0001A008, PLL configuration (0x110, 0x114, 0x118) reads 0x00014000, PLL status (0x10C) reads 0x0000003F, secure-config (0x000) reads 0, reset control (0x200) reads 0, and `acc_err` and `soft_rst_req` are low.
- R2: A write to the lock register (0x004) whose bits [15:0] equal 0x767B locks the block, whatever the upper bits hold. Any other value leaves the lock state unchanged and raises no error.
- R3: A write to the unlock register (0x008) whose bits [15:0] equal 0xDF0D unlocks the block, whatever the upper bits hold. Any other value leaves the lock state unchanged and raises no error. Both key registers accept writes while locked.
- R4: While locked, a write to any read/write register (0x000, 0x100–0x108, 0x110–0x118, 0x200) is discarded and `acc_err` pulses.
- R5: The lock and unlock registers are write-only. Lock status and PLL status are read-only. A read of a write-only offset returns 0 with `acc_err`. A write to a read-only offset changes nothing and raises `acc_err`.
- R6: Every other offset is unmapped. A read there returns 0 with `acc_err`. A write there changes nothing and raises `acc_err`.
- R7: `rd_data` and `acc_err` are due in the cycle after the request. `acc_err` is high for exactly that one cycle per offending request and is low otherwise.
- R8: An accepted write to reset control with bit 0 set stores the value and makes `soft_rst_req` high for exactly the next cycle. A write refused by the lock produces no pulse, and neither does a write with bit 0 clear.
- R9: The secure-config register keeps only bit 0 of a written value. Its bits [31:1] always read 0.
- R10: When unlocked, the PLL control, PLL configuration and reset-control registers store and read back all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request taken on this edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address; bits [11:2] select the word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered; 0 after a refused read |
| acc_err | output | 1 | One-cycle pulse flagging an illegal or locked access |
| soft_rst_req | output | 1 | One-cycle system soft-reset request |

## Verification
Every result is due exactly one clock after its request: read data, the error pulse and the soft-reset pulse all come out of a single register stage. The bench drives each request on a falling edge and samples all three outputs on the next falling edge, which lies half a cycle after the capturing rising edge. Where one-cycle width matters, the bench adds an idle cycle after the request and samples `soft_rst_req` again at the falling edge that follows. That sample must be low. A bench model of the lock and register contents predicts every sampled value, and random requests are weighted toward the key values and the mapped offsets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    typedef enum logic [1:0] {AC_RW, AC_RO, AC_WO, AC_NONE} acc_class_e;

    typedef enum logic [3:0] {
        SEL_SEC, SEL_LOCK, SEL_UNLOCK, SEL_LSTAT,
        SEL_PLLC, SEL_PSTAT, SEL_PLLG, SEL_RST, SEL_NONE
    } reg_sel_e;

    localparam logic [15:0] LOCK_KEY   = 16'h767B;
    localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;
    localparam logic [31:0] PLLC_RST   = 32'h0001_A008;
    localparam logic [31:0] PLLG_RST   = 32'h0001_4000;
    localparam logic [31:0] PSTAT_VAL  = 32'h0000_003F;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int WORD_W  = 10,
    parameter int NUM_PLL = 3,
    parameter int IDX_W   = 2
) (
    input  logic [WORD_W-1:0] word,
    output acc_class_e        cls,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [WORD_W-1:0] W_SEC    = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_LOCK   = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_UNLOCK = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_LSTAT  = WORD_W'(3);
    localparam logic [WORD_W-1:0] W_PLLC   = WORD_W'(32'h100 / 4);
    localparam logic [WORD_W-1:0] W_PSTAT  = WORD_W'(32'h100 / 4 + NUM_PLL);
    localparam logic [WORD_W-1:0] W_PLLG   = WORD_W'(32'h100 / 4 + NUM_PLL + 1);
    localparam logic [WORD_W-1:0] W_RST    = WORD_W'(32'h200 / 4);
    localparam logic [WORD_W-1:0] W_NPLL   = WORD_W'(NUM_PLL);

    always_comb begin
        cls = AC_NONE;
        sel = SEL_NONE;
        idx = '0;
        if (word == W_SEC) begin
            cls = AC_RW; sel = SEL_SEC;
        end else if (word == W_LOCK) begin
            cls = AC_WO; sel = SEL_LOCK;
        end else if (word == W_UNLOCK) begin
            cls = AC_WO; sel = SEL_UNLOCK;
        end else if (word == W_LSTAT) begin
            cls = AC_RO; sel = SEL_LSTAT;
        end else if (word >= W_PLLC && word < W_PLLC + W_NPLL) begin
            cls = AC_RW; sel = SEL_PLLC; idx = IDX_W'(word - W_PLLC);
        end else if (word == W_PSTAT) begin
            cls = AC_RO; sel = SEL_PSTAT;
        end else if (word >= W_PLLG && word < W_PLLG + W_NPLL) begin
            cls = AC_RW; sel = SEL_PLLG; idx = IDX_W'(word - W_PLLG);
        end else if (word == W_RST) begin
            cls = AC_RW; sel = SEL_RST;
        end
    end
endmodule

// File: rtl/sysctl_lock_fsm.sv
module sysctl_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_hit,
    input  logic unlock_hit,
    output logic locked
);
    typedef enum logic {ST_LOCKED, ST_OPEN} lock_state_e;
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (unlock_hit) state_d = ST_OPEN;    // UNLOCK_KEY_SEEN
            ST_OPEN:   if (lock_hit)   state_d = ST_LOCKED;  // LOCK_KEY_SEEN
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_LOCKED: locked = 1'b1;
            ST_OPEN:   locked = 1'b0;
            default:   locked = 1'b1;
        endcase
    end

    // R2
    lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lock_hit));
    // R3
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(unlock_hit));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_PLL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    output logic              soft_rst_req
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;

    acc_class_e       cls;
    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic             locked;

    logic [DATA_W-1:0] pllc_q [NUM_PLL];
    logic [DATA_W-1:0] pllg_q [NUM_PLL];
    logic [DATA_W-1:0] rst_ctrl_q;
    logic              sec_q;

    sysctl_decode #(.WORD_W(WORD_W), .NUM_PLL(NUM_PLL), .IDX_W(IDX_W)) u_dec (
        .word(req_addr[ADDR_W-1:2]), .cls(cls), .sel(sel), .idx(idx)
    );

    logic wr, rd, bad_class, lock_block, wr_ok, err_d, lock_hit, unlock_hit;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        wr         = req_valid && req_write;
        rd         = req_valid && !req_write;
        bad_class  = (cls == AC_NONE) || (wr && cls == AC_RO) || (rd && cls == AC_WO);
        lock_block = wr && (cls == AC_RW) && locked;
        wr_ok      = wr && (cls == AC_RW) && !locked;
        err_d      = req_valid && (bad_class || lock_block);
        lock_hit   = wr && (sel == SEL_LOCK)   && (req_wdata[15:0] == LOCK_KEY);
        unlock_hit = wr && (sel == SEL_UNLOCK) && (req_wdata[15:0] == UNLOCK_KEY);
    end

    sysctl_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .lock_hit(lock_hit),
        .unlock_hit(unlock_hit), .locked(locked)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pllc_q[g] <= PLLC_RST;
                pllg_q[g] <= PLLG_RST;
            end else if (wr_ok && idx == IDX_W'(g)) begin
                if (sel == SEL_PLLC) pllc_q[g] <= req_wdata;
                if (sel == SEL_PLLG) pllg_q[g] <= req_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q      <= 1'b0;
            rst_ctrl_q <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_SEC) sec_q      <= req_wdata[0];
            if (sel == SEL_RST) rst_ctrl_q <= req_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SEC:   rd_val = DATA_W'(sec_q);
            SEL_LSTAT: rd_val = DATA_W'(locked);
            SEL_PLLC:  rd_val = pllc_q[idx];
            SEL_PSTAT: rd_val = PSTAT_VAL;
            SEL_PLLG:  rd_val = pllg_q[idx];
            SEL_RST:   rd_val = rst_ctrl_q;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data      <= '0;
            acc_err      <= 1'b0;
            soft_rst_req <= 1'b0;
        end else begin
            acc_err      <= err_d;
            soft_rst_req <= wr_ok && (sel == SEL_RST) && req_wdata[0];
            if (rd) rd_data <= err_d ? '0 : rd_val;
        end
    end

    // R8
    soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(req_valid && req_write && !locked && req_wdata[0]
                               && sel == SEL_RST));
    // R4
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_write && locked && cls == AC_RW))
            |-> (acc_err && $stable(rst_ctrl_q) && $stable(sec_q)));
    // R5
    wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && cls == AC_WO) |-> (acc_err && rd_data == '0));
    // R7
    err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(req_valid));
    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && $past(req_valid && !req_write)) |-> rd_data == '0);
endmodule

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        acc_err;
    logic        soft_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sysctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .acc_err(acc_err), .soft_rst_req(soft_rst_req)
    );

    // bench model
    bit          m_locked;
    bit          m_sec;
    logic [31:0] m_pllc [3];
    logic [31:0] m_pllg [3];
    logic [31:0] m_rst;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 rw, 1 ro, 2 wo, 3 unmapped
    function automatic int cls_of(logic [11:0] a);
        logic [9:0] w = a[11:2];
        if (w == 10'd0) return 0;
        if (w == 10'd1 || w == 10'd2) return 2;
        if (w == 10'd3 || w == 10'h43) return 1;
        if ((w >= 10'h40 && w <= 10'h42) || (w >= 10'h44 && w <= 10'h46)) return 0;
        if (w == 10'h80) return 0;
        return 3;
    endfunction

    function automatic logic [31:0] model_val(logic [11:0] a);
        logic [9:0] w = a[11:2];
        if (w == 10'd0) return {31'b0, m_sec};
        if (w == 10'd3) return {31'b0, m_locked};
        if (w >= 10'h40 && w <= 10'h42) return m_pllc[w - 10'h40];
        if (w == 10'h43) return 32'h3F;
        if (w >= 10'h44 && w <= 10'h46) return m_pllg[w - 10'h44];
        if (w == 10'h80) return m_rst;
        return 32'h0;
    endfunction

    task automatic access(string tag, bit wr, logic [11:0] a, logic [31:0] d);
        int c = cls_of(a);
        bit e_err, e_soft, ok;
        logic [31:0] e_rd;
        e_err  = (c == 3) || (wr && c == 1) || (!wr && c == 2) || (wr && c == 0 && m_locked);
        ok     = wr && c == 0 && !m_locked;
        e_soft = ok && a[11:2] == 10'h80 && d[0];
        e_rd   = e_err ? 32'h0 : model_val(a);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " acc_err"}, 32'(acc_err), 32'(e_err));
        check({tag, " soft_rst_req"}, 32'(soft_rst_req), 32'(e_soft));
        if (!wr) check({tag, " rd_data"}, rd_data, e_rd);
        if (ok) begin
            case (a[11:2])
                10'h0:  m_sec = d[0];
                10'h40, 10'h41, 10'h42: m_pllc[a[11:2] - 10'h40] = d;
                10'h44, 10'h45, 10'h46: m_pllg[a[11:2] - 10'h44] = d;
                10'h80: m_rst = d;
                default: ;
            endcase
        end
        if (wr && c == 2) begin
            if (a[11:2] == 10'd1 && d[15:0] == 16'h767B) m_locked = 1;
            if (a[11:2] == 10'd2 && d[15:0] == 16'hDF0D) m_locked = 0;
        end
    endtask

    task automatic idle_check_soft(string tag);
        @(negedge clk);
        check(tag, 32'(soft_rst_req), 32'h0);
        check({tag, " err"}, 32'(acc_err), 32'h0);
    endtask

    function automatic logic [11:0] pick_addr();
        case ($urandom % 16)
            0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
            3: return 12'h00C;  4: return 12'h100;  5: return 12'h104;
            6: return 12'h108;  7: return 12'h10C;  8: return 12'h110;
            9: return 12'h118; 10: return 12'h200; 11: return 12'h200;
           12: return 12'h114; 13: return 12'h204;
            default: return 12'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] pick_data();
        case ($urandom % 6)
            0: return {16'($urandom), 16'h767B};
            1: return {16'($urandom), 16'hDF0D};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        m_locked = 1; m_sec = 0; m_rst = 0;
        for (int i = 0; i < 3; i++) begin
            m_pllc[i] = 32'h0001A008;
            m_pllg[i] = 32'h00014000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 acc_err reset", 32'(acc_err), 32'h0);
        check("R1 soft_rst_req reset", 32'(soft_rst_req), 32'h0);
        access("R1 lock status", 0, 12'h00C, 0);
        access("R1 pll ctrl0", 0, 12'h100, 0);
        access("R1 pll ctrl2", 0, 12'h108, 0);
        access("R1 pll status", 0, 12'h10C, 0);
        access("R1 pll cfg1", 0, 12'h114, 0);
        access("R1 sec cfg", 0, 12'h000, 0);
        access("R1 rst ctrl", 0, 12'h200, 0);
        // R4 locked writes dropped
        access("R4 locked pll write", 1, 12'h104, 32'hDEADBEEF);
        access("R4 readback", 0, 12'h104, 0);
        access("R4 locked rst write", 1, 12'h200, 32'h1);
        idle_check_soft("R8 no pulse when locked");
        // R3 unlock keys
        access("R3 wrong key", 1, 12'h008, 32'h0000DF0C);
        access("R3 still locked", 0, 12'h00C, 0);
        access("R3 key upper bits", 1, 12'h008, 32'hABCDDF0D);
        access("R3 unlocked", 0, 12'h00C, 0);
        // R10 full width storage
        access("R10 pll ctrl write", 1, 12'h108, 32'hA5A5_5A5A);
        access("R10 pll ctrl read", 0, 12'h108, 0);
        access("R10 pll cfg write", 1, 12'h110, 32'hFFFF_FFFF);
        access("R10 pll cfg read", 0, 12'h110, 0);
        // R9 secure config bit 0
        access("R9 sec write even", 1, 12'h000, 32'hFFFF_FFFE);
        access("R9 sec read", 0, 12'h000, 0);
        access("R9 sec write odd", 1, 12'h000, 32'h8000_0003);
        access("R9 sec read1", 0, 12'h000, 0);
        // R5 access classes
        access("R5 ro write lstat", 1, 12'h00C, 32'h1);
        access("R5 ro write pstat", 1, 12'h10C, 32'h0);
        access("R5 pstat read", 0, 12'h10C, 0);
        access("R5 wo read lock", 0, 12'h004, 0);
        access("R5 wo read unlock", 0, 12'h008, 0);
        // R6 unmapped
        access("R6 unmapped read", 0, 12'h300, 0);
        access("R6 unmapped write", 1, 12'hFFC, 32'h1234);
        access("R6 gap read", 0, 12'h11C, 0);
        // R8 soft reset pulse
        access("R8 soft reset", 1, 12'h200, 32'h0000_0005);
        idle_check_soft("R8 pulse one cycle");
        access("R8 stored", 0, 12'h200, 0);
        access("R8 bit0 clear", 1, 12'h200, 32'h0000_0004);
        // R2 lock keys
        access("R2 wrong key", 1, 12'h004, 32'h0000_767A);
        access("R2 still open", 0, 12'h00C, 0);
        access("R2 lock", 1, 12'h004, 32'h1111_767B);
        access("R2 locked", 0, 12'h00C, 0);
        access("R2 sec blocked", 1, 12'h000, 32'h0);
        access("R2 sec unchanged", 0, 12'h000, 0);
        // R7 back-to-back then idle
        idle_check_soft("R7 idle");
        // random mix
        for (int k = 0; k < 600; k++) begin
            access("R7 random", 1'($urandom % 2), pick_addr(), pick_data());
            if ($urandom % 8 == 0) idle_check_soft("R7 random idle");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule